// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Comparator with Lock Detection

This block serves two synthesizer loops. For each loop it compares a divided reference pulse train with a divided oscillator pulse train. It produces a charge-pump command made of two enables, raise and lower. When both enables are low, the pump is in its high-impedance state. A polarity input per channel swaps the meaning of the two enables, so that the block fits either slope of oscillator tuning. When the two edges arrive together, both enables still pulse for one cycle. This removes the dead zone around zero phase error.

Every register runs on the sampling oscillator clock, and the phase error is counted in cycles of that clock. A channel drops its lock flag when an error pulse grows to four cycles. It regains lock only after three comparisons in a row whose error was two cycles or less. A per-channel sleep input does four things: it idles the pump, clears the detector, makes the channel count as locked, and holds the detector clear after wake-up until the first reference edge arrives.

Both lock flags are merged into one output pin. A monitor mode can instead route any of the four input pulse trains to that same pin for test.

Top module: `dual_pfd_lock`

## Requirements
- R1: With polarity 1, if the reference edge leads the oscillator edge by d cycles, raise stays high for d+1 cycles and lower for 1 cycle. If the oscillator edge leads by d cycles, lower stays high for d+1 cycles and raise for 1 cycle.
- R2: With polarity 0, the roles of raise and lower in R1 are swapped.
- R3: Edges that arrive in the same cycle give exactly one cycle with both raise and lower high. With no edge pending, both are low (high impedance), and both are never high in two consecutive cycles.
- R4: When an error pulse lasts four cycles, the lock flag falls in the very next cycle, before the lagging edge arrives. An error of three cycles leaves a held lock in place.
- R5: Lock rises after the third consecutive comparison with an error of at most two cycles. A comparison with an error of three cycles breaks the run.
- R6: After reset, all enables are low, both lock flags are low, and each detector ignores oscillator edges until its first reference edge.
- R7: While a channel's sleep input is 1, its raise and lower are low, and it counts as locked in the merged flag. Its own lock state is cleared, so after wake-up it reads as unlocked.
- R8: After sleep is released, oscillator edges produce no pump activity until the first reference edge.
- R9: With monitor mode 0, the shared pin is 1 only when each channel is either locked or sleeping.
- R10: With monitor mode 1, the shared pin carries a signal chosen by mon_sel: mon_sel[1]=0 selects a reference input and 1 selects an oscillator input, and mon_sel[0]=0 selects channel A and 1 selects channel B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_a | input | 1 | Channel A divided reference pulse |
| vco_a | input | 1 | Channel A divided oscillator pulse |
| pol_a | input | 1 | Channel A pump polarity |
| sleep_a | input | 1 | Channel A power save |
| ref_b | input | 1 | Channel B divided reference pulse |
| vco_b | input | 1 | Channel B divided oscillator pulse |
| pol_b | input | 1 | Channel B pump polarity |
| sleep_b | input | 1 | Channel B power save |
| mon_en | input | 1 | 1 puts a monitor signal on the shared pin, 0 puts the merged lock on it |
| mon_sel | input | 2 | Monitor select, see R10 |
| up_a | output | 1 | Channel A raise enable |
| dn_a | output | 1 | Channel A lower enable |
| up_b | output | 1 | Channel B raise enable |
| dn_b | output | 1 | Channel B lower enable |
| shared_o | output | 1 | Merged lock or monitor output |

## Verification
The comparator is driven with edge pairs in which the reference leads, the oscillator leads, or both edges coincide, under each polarity. The counted raise and lower cycles distinguish the lead direction, the polarity swap and the anti-dead-zone pulse. The lock path is driven with error widths of 0, 1, 2, 3, 4 and 5 cycles. A width of 2 against 3 separates a good comparison from a run breaker, and 3 against 4 separates holding lock from dropping it, with the cycle of the drop checked exactly. Lone oscillator pulses after reset and after wake-up show whether the detector stays disarmed until a reference edge arrives.

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
  parameter int UNLOCK_CYC = 4,
  parameter int RELOCK_CYC = 2,
  parameter int GOOD_RUNS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_a,
  input  logic       vco_a,
  input  logic       pol_a,
  input  logic       sleep_a,
  input  logic       ref_b,
  input  logic       vco_b,
  input  logic       pol_b,
  input  logic       sleep_b,
  input  logic       mon_en,
  input  logic [1:0] mon_sel,
  output logic       up_a,
  output logic       dn_a,
  output logic       up_b,
  output logic       dn_b,
  output logic       shared_o
);
  localparam int WW = $clog2(UNLOCK_CYC + 1);
  localparam int GW = $clog2(GOOD_RUNS + 1);

  logic [1:0] ref_i, vco_i, pol_i, slp_i, up_o, dn_o, lk;
  logic       mon_bit;

  assign ref_i = {ref_b, ref_a};
  assign vco_i = {vco_b, vco_a};
  assign pol_i = {pol_b, pol_a};
  assign slp_i = {sleep_b, sleep_a};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic          ref_q, vco_q, r, v, arm, lock;
    logic [WW-1:0] w;
    logic [GW-1:0] good;
    logic          ref_rise, vco_rise, arm_n, both, err;

    assign ref_rise = ref_i[c] & ~ref_q;
    assign vco_rise = vco_i[c] & ~vco_q;
    assign arm_n    = arm | ref_rise;
    assign both     = r & v;
    assign err      = r ^ v;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q <= 1'b0; vco_q <= 1'b0; r <= 1'b0; v <= 1'b0;
        arm <= 1'b0; lock <= 1'b0; w <= '0; good <= '0;
      end else begin
        ref_q <= ref_i[c];
        vco_q <= vco_i[c];
        if (slp_i[c]) begin
          arm <= 1'b0; r <= 1'b0; v <= 1'b0;
          w <= '0; good <= '0; lock <= 1'b0;
        end else begin
          arm <= arm_n;
          if (!arm_n || both) begin
            r <= 1'b0;
            v <= 1'b0;
          end else begin
            r <= r | ref_rise;
            v <= v | vco_rise;
          end
          if (err)
            w <= (w == WW'(UNLOCK_CYC)) ? w : w + 1'b1;
          else if (!both)
            w <= '0;
          if (err && w >= WW'(UNLOCK_CYC - 1)) begin
            lock <= 1'b0;
            good <= '0;
          end else if (both) begin
            if (w <= WW'(RELOCK_CYC)) begin
              good <= (good == GW'(GOOD_RUNS)) ? good : good + 1'b1;
              if (good >= GW'(GOOD_RUNS - 1)) lock <= 1'b1;
            end else begin
              good <= '0;
            end
          end
        end
      end
    end

    assign up_o[c] = ~slp_i[c] & (pol_i[c] ? r : v);
    assign dn_o[c] = ~slp_i[c] & (pol_i[c] ? v : r);
    assign lk[c]   = slp_i[c] | lock;
  end

  assign mon_bit  = mon_sel[1] ? vco_i[mon_sel[0]] : ref_i[mon_sel[0]];
  assign shared_o = mon_en ? mon_bit : &lk;

  assign up_a = up_o[0];
  assign dn_a = dn_o[0];
  assign up_b = up_o[1];
  assign dn_b = dn_o[1];
endmodule

// File: rtl/dual_pfd_lock_checker.sv
module dual_pfd_lock_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_a,
  input logic       sleep_a,
  input logic       sleep_b,
  input logic       mon_en,
  input logic [1:0] mon_sel,
  input logic       up_a,
  input logic       dn_a,
  input logic       up_b,
  input logic       dn_b,
  input logic       shared_o
);
  assert_sleep_hiz_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_a |-> (!up_a && !dn_a));
  assert_sleep_hiz_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_b |-> (!up_b && !dn_b));
  assert_single_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_a && dn_a) |=> !(up_a && dn_a));
  assert_wake_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_a) |-> (!up_a && !dn_a));
  assert_sleepers_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && sleep_a && sleep_b) |-> shared_o);
  assert_monitor_ref_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && mon_sel == 2'b00) |-> (shared_o == ref_a));
endmodule

bind dual_pfd_lock dual_pfd_lock_checker u_checker (
  .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .sleep_a(sleep_a), .sleep_b(sleep_b),
  .mon_en(mon_en), .mon_sel(mon_sel), .up_a(up_a), .dn_a(dn_a), .up_b(up_b),
  .dn_b(dn_b), .shared_o(shared_o)
);

// File: tb/dual_pfd_lock_bench.sv
`timescale 1ns/1ps
module dual_pfd_lock_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_a = 0, vco_a = 0, pol_a = 1, sleep_a = 0;
  logic ref_b = 0, vco_b = 0, pol_b = 1, sleep_b = 0;
  logic mon_en = 0;
  logic [1:0] mon_sel = 2'b00;
  logic up_a, dn_a, up_b, dn_b, shared_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dual_pfd_lock u_dual_pfd_lock (
    .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .vco_a(vco_a), .pol_a(pol_a),
    .sleep_a(sleep_a), .ref_b(ref_b), .vco_b(vco_b), .pol_b(pol_b),
    .sleep_b(sleep_b), .mon_en(mon_en), .mon_sel(mon_sel), .up_a(up_a),
    .dn_a(dn_a), .up_b(up_b), .dn_b(dn_b), .shared_o(shared_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pair(input int ch, input int lead, output int ups, output int dns);
    int tr = (lead < 0) ? -lead : 0;
    int tv = (lead > 0) ? lead : 0;
    int span = ((lead < 0) ? -lead : lead) + 4;
    ups = 0; dns = 0;
    for (int i = 0; i <= span; i++) begin
      @(negedge clk);
      if (ch == 0) begin
        ups += int'(up_a); dns += int'(dn_a);
        ref_a = (i == tr); vco_a = (i == tv);
      end else begin
        ups += int'(up_b); dns += int'(dn_b);
        ref_b = (i == tr); vco_b = (i == tv);
      end
    end
  endtask

  task automatic lone_vco_a(input string tag);
    int act = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      act += int'(up_a) + int'(dn_a);
      vco_a = (i == 0);
    end
    chk(tag, act, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R6 reset enables", int'(up_a) + int'(dn_a) + int'(up_b) + int'(dn_b), 0);
    chk("R6 reset lock", int'(shared_o), 0);
    lone_vco_a("R6 disarmed vco ignored");
  endtask

  task automatic t_lead;
    int u, d;
    sleep_b = 1; pol_a = 1;
    pair(0, 3, u, d);
    chk("R1 ref lead up", u, 4); chk("R1 ref lead dn", d, 1);
    pair(0, -2, u, d);
    chk("R1 vco lead up", u, 1); chk("R1 vco lead dn", d, 3);
  endtask

  task automatic t_pol;
    int u, d;
    pol_a = 0;
    pair(0, 3, u, d);
    chk("R2 swapped up", u, 1); chk("R2 swapped dn", d, 4);
    pol_a = 1;
  endtask

  task automatic t_zero;
    int u, d;
    pair(0, 0, u, d);
    chk("R3 coincident up", u, 1); chk("R3 coincident dn", d, 1);
    @(negedge clk);
    chk("R3 idle hi-z", int'(up_a) + int'(dn_a), 0);
  endtask

  task automatic t_lock;
    int u, d;
    pair(0, 5, u, d); chk("R4 wide error unlocked", int'(shared_o), 0);
    pair(0, 2, u, d); pair(0, -1, u, d);
    chk("R5 two good not locked", int'(shared_o), 0);
    pair(0, 3, u, d); chk("R5 width3 no lock", int'(shared_o), 0);
    pair(0, 0, u, d); pair(0, 2, u, d);
    chk("R5 run restarted", int'(shared_o), 0);
    pair(0, 1, u, d); chk("R5 third good locks", int'(shared_o), 1);
    pair(0, 3, u, d); chk("R4 width3 keeps lock", int'(shared_o), 1);
  endtask

  task automatic t_unlock;
    int s4 = 0, s5 = 0;
    for (int i = 0; i <= 10; i++) begin
      @(negedge clk);
      if (i == 4) s4 = int'(shared_o);
      if (i == 5) s5 = int'(shared_o);
      ref_a = (i == 0); vco_a = (i == 7);
    end
    chk("R4 lock before 4th cycle", s4, 1);
    chk("R4 lock drops at once", s5, 0);
    chk("R4 stays unlocked", int'(shared_o), 0);
  endtask

  task automatic t_sleep_merge;
    int u, d;
    sleep_a = 1;
    pair(0, 3, u, d);
    chk("R7 sleep idles pump", u + d, 0);
    chk("R9 both asleep merged", int'(shared_o), 1);
    sleep_b = 0; pol_b = 1;
    @(negedge clk);
    chk("R9 b awake unlocked", int'(shared_o), 0);
    pair(1, 1, u, d); pair(1, 1, u, d); pair(1, 1, u, d);
    chk("R9 b locked a asleep", int'(shared_o), 1);
    sleep_a = 0;
    @(negedge clk);
    chk("R7 a cleared by sleep", int'(shared_o), 0);
  endtask

  task automatic t_wake;
    int u, d;
    lone_vco_a("R8 vco ignored after wake");
    pair(0, 2, u, d);
    chk("R8 ref rearms up", u, 3); chk("R8 ref rearms dn", d, 1);
    pair(0, 1, u, d); pair(0, 1, u, d);
    chk("R9 both locked", int'(shared_o), 1);
    pair(1, 5, u, d);
    chk("R9 b unlocked merged low", int'(shared_o), 0);
  endtask

  task automatic t_mux;
    sleep_a = 1; sleep_b = 1; mon_en = 1;
    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 4; h++) begin
        @(negedge clk);
        mon_sel = 2'(s);
        ref_a = (h == 0); ref_b = (h == 1); vco_a = (h == 2); vco_b = (h == 3);
        #1;
        chk($sformatf("R10 sel %0d hot %0d", s, h), int'(shared_o), int'(s == h));
      end
    end
    @(negedge clk);
    ref_a = 0; ref_b = 0; vco_a = 0; vco_b = 0; mon_en = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog all R: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lead();
    t_pol();
    t_zero();
    t_lock();
    t_unlock();
    t_sleep_merge();
    t_wake();
    t_mux();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule